// File: doc/BRIEF.md
# One-Time-Programmable Page Write Decoder

This block sits behind a serial bus byte receiver. It sees start and stop strobes and each received byte with a valid strobe. From these it recognises the command sequence that writes the one-time-programmable (OTP) page of a non-volatile memory. The sequence is a fixed select byte, then two address bytes with fixed patterns, then any number of data bytes, closed by a stop.

The block answers every byte with an acknowledge decision one cycle later. For each accepted data byte it raises a write strobe together with the byte and its offset in the page. A wrong bit in the select byte or in either address byte gives a silent non-acknowledge. The whole command is then dropped until the next start. Permission to program the page comes from the protection logic on a single input. When that input is low, data bytes are refused.

Top module: `otp_page_write_decoder`

## Requirements
- R1: After reset, `ack_vld_o`, `ack_o` and `otp_we_o` are low and the decoder is idle.
- R2: After a start, the first byte is acknowledged only if it equals 8'hA2. The answer appears on `ack_vld_o`/`ack_o` in the cycle after the byte's valid cycle.
- R3: A first byte that differs from 8'hA2 in any bit is not acknowledged. Every later byte is also not acknowledged until a new start.
- R4: The second byte (address high) is acknowledged when bits [3:0] are zero, whatever bits [7:4] hold. Otherwise it is not acknowledged and the command is dropped until the next start.
- R5: The third byte (address low) is acknowledged only when it equals 8'h00. Otherwise it is not acknowledged and the command is dropped.
- R6: With `wr_permit_i` high, each data byte after the address is acknowledged. In the same cycle as that acknowledge, `otp_we_o` pulses and `otp_data_o` carries the byte.
- R7: `otp_off_o` is 0 for the first data byte of a command, rises by one for each accepted data byte, and wraps from 63 to 0.
- R8: With `wr_permit_i` low, a data byte is not acknowledged, no write strobe is raised, and the command is dropped.
- R9: A stop anywhere in the sequence returns the decoder to idle. A start anywhere makes the next byte a select byte. A byte valid in the same cycle as a start or stop gets no response.
- R10: Bytes received while idle (before any start, or after a stop) are not acknowledged and cause no write.
- R11: `ack_vld_o` is high exactly in the cycles that follow a byte valid cycle without a start or stop. `otp_we_o` is never high without `ack_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Bus start (or repeated start) strobe |
| stop_i | input | 1 | Bus stop strobe |
| byte_vld_i | input | 1 | Received byte valid strobe |
| byte_i | input | 8 | Received byte |
| wr_permit_i | input | 1 | OTP programming allowed by protection logic |
| ack_vld_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| otp_we_o | output | 1 | OTP byte write strobe |
| otp_off_o | output | 6 | Byte offset in the page for the write |
| otp_data_o | output | 8 | Byte to write |

## Verification
All 256 values are swept through the select, address-high and address-low positions. The sweep separates exact matching from nibble masking, and after each refusal the next byte shows that the command was really dropped. Address high is tried with non-zero upper bits in the data runs, to show that those bits are don't-care. A data run longer than the page tells wrapping from plain counting. Separate cases cover the permit input being low, a stop or a start in the middle of a command, and a start in the same cycle as a byte. These show that an abort restarts the offset and that a collision gives no response.

// File: rtl/otp_dec_pkg.sv
package otp_dec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEL  = 3'd1,
    ST_ADRH = 3'd2,
    ST_ADRL = 3'd3,
    ST_DATA = 3'd4
  } dec_state_e;

  // exact compare of the select byte
  function automatic logic select_ok(input logic [7:0] b, input logic [7:0] code);
    return b == code;
  endfunction

  // only the bits set in must_zero are checked, all must be clear
  function automatic logic pattern_ok(input logic [7:0] b, input logic [7:0] must_zero);
    return (b & must_zero) == 8'h00;
  endfunction

  // increment with wrap at n
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/otp_byte_classifier.sv
module otp_byte_classifier
  import otp_dec_pkg::*;
#(
  parameter logic [7:0] SEL_CODE  = 8'hA2,
  parameter logic [7:0] ADRH_ZERO = 8'h0F,
  parameter logic [7:0] ADRL_ZERO = 8'hFF
) (
  input  logic [7:0] byte_i,
  output logic       sel_match_o,
  output logic       adrh_match_o,
  output logic       adrl_match_o
);
  always_comb begin
    sel_match_o  = select_ok(byte_i, SEL_CODE);
    adrh_match_o = pattern_ok(byte_i, ADRH_ZERO);
    adrl_match_o = pattern_ok(byte_i, ADRL_ZERO);
  end
endmodule

// File: rtl/otp_seq_fsm.sv
module otp_seq_fsm
  import otp_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       byte_vld_i,
  input  logic       wr_permit_i,
  input  logic       sel_match_i,
  input  logic       adrh_match_i,
  input  logic       adrl_match_i,
  output dec_state_e state_o,
  output logic       byte_evt_o,
  output logic       accept_o,
  output logic       addr_done_o,
  output logic       wr_evt_o
);
  dec_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    byte_evt_o  = 1'b0;
    accept_o    = 1'b0;
    addr_done_o = 1'b0;
    wr_evt_o    = 1'b0;
    if (start_i) begin
      state_d = ST_SEL;
    end else if (stop_i) begin
      state_d = ST_IDLE;
    end else if (byte_vld_i) begin
      byte_evt_o = 1'b1;
      unique case (state_q)
        ST_SEL: begin
          accept_o = sel_match_i;
          state_d  = sel_match_i ? ST_ADRH : ST_IDLE;
        end
        ST_ADRH: begin
          accept_o = adrh_match_i;
          state_d  = adrh_match_i ? ST_ADRL : ST_IDLE;
        end
        ST_ADRL: begin
          accept_o    = adrl_match_i;
          addr_done_o = adrl_match_i;
          state_d     = adrl_match_i ? ST_DATA : ST_IDLE;
        end
        ST_DATA: begin
          accept_o = wr_permit_i;
          wr_evt_o = wr_permit_i;
          state_d  = wr_permit_i ? ST_DATA : ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/otp_offset_ctr.sv
module otp_offset_ctr
  import otp_dec_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 64,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [OFF_W-1:0] off_o
);
  logic [OFF_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= OFF_W'(wrap_inc(int'(cnt_q), PAGE_BYTES));
  end

  assign off_o = cnt_q;
endmodule

// File: rtl/otp_page_write_decoder.sv
module otp_page_write_decoder
  import otp_dec_pkg::*;
#(
  parameter logic [7:0]  SEL_CODE   = 8'hA2,
  parameter int unsigned PAGE_BYTES = 64,
  localparam int unsigned OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic             wr_permit_i,
  output logic             ack_vld_o,
  output logic             ack_o,
  output logic             otp_we_o,
  output logic [OFF_W-1:0] otp_off_o,
  output logic [7:0]       otp_data_o
);
  // named internal events, visible to the checker
  logic       sel_match, adrh_match, adrl_match;
  logic       byte_evt, accept, addr_done, wr_evt;
  logic       data_phase;
  dec_state_e state;
  logic [OFF_W-1:0] cur_off;

  otp_byte_classifier #(
    .SEL_CODE  (SEL_CODE),
    .ADRH_ZERO (8'h0F),
    .ADRL_ZERO (8'hFF)
  ) u_cls (
    .byte_i       (byte_i),
    .sel_match_o  (sel_match),
    .adrh_match_o (adrh_match),
    .adrl_match_o (adrl_match)
  );

  otp_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .byte_vld_i   (byte_vld_i),
    .wr_permit_i  (wr_permit_i),
    .sel_match_i  (sel_match),
    .adrh_match_i (adrh_match),
    .adrl_match_i (adrl_match),
    .state_o      (state),
    .byte_evt_o   (byte_evt),
    .accept_o     (accept),
    .addr_done_o  (addr_done),
    .wr_evt_o     (wr_evt)
  );

  otp_offset_ctr #(.PAGE_BYTES(PAGE_BYTES)) u_off (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (addr_done),
    .step_i  (wr_evt),
    .off_o   (cur_off)
  );

  assign data_phase = (state == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_vld_o  <= 1'b0;
      ack_o      <= 1'b0;
      otp_we_o   <= 1'b0;
      otp_off_o  <= '0;
      otp_data_o <= '0;
    end else begin
      ack_vld_o <= byte_evt;
      ack_o     <= accept;
      otp_we_o  <= wr_evt;
      if (wr_evt) begin
        otp_off_o  <= cur_off;
        otp_data_o <= byte_i;
      end
    end
  end
endmodule

// File: rtl/otp_page_write_decoder_chk.sv
module otp_page_write_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic stop_i,
  input logic byte_vld_i,
  input logic wr_permit_i,
  input logic ack_vld_o,
  input logic ack_o,
  input logic otp_we_o,
  input logic data_phase
);
  AST_WE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    otp_we_o |-> (ack_o && ack_vld_o)); // R11
  AST_RESP_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && !start_i && !stop_i) |=> ack_vld_o); // R11
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld_i && !start_i && !stop_i) |=> !ack_vld_o); // R9
  AST_WE_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    otp_we_o |-> $past(wr_permit_i)); // R8
  AST_ABORT_LEAVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i || stop_i) |=> !data_phase); // R9
  AST_ACK_NOT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> ack_vld_o); // R11
endmodule

bind otp_page_write_decoder otp_page_write_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .byte_vld_i  (byte_vld_i),
  .wr_permit_i (wr_permit_i),
  .ack_vld_o   (ack_vld_o),
  .ack_o       (ack_o),
  .otp_we_o    (otp_we_o),
  .data_phase  (data_phase)
);

// File: tb/otp_page_write_decoder_test.sv
module otp_page_write_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0, wr_permit_i = 1'b1;
  logic [7:0] byte_i = 8'h00;
  logic       ack_vld_o, ack_o, otp_we_o;
  logic [5:0] otp_off_o;
  logic [7:0] otp_data_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic r_vld, r_ack, r_we;
  logic [5:0] r_off;
  logic [7:0] r_data;

  always #5 clk = ~clk;

  otp_page_write_decoder uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .wr_permit_i(wr_permit_i),
    .ack_vld_o(ack_vld_o), .ack_o(ack_o), .otp_we_o(otp_we_o),
    .otp_off_o(otp_off_o), .otp_data_o(otp_data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
  endtask

  // byte in one cycle, response sampled at the following negedge
  task automatic send(input logic [7:0] b);
    @(negedge clk) begin byte_vld_i = 1'b1; byte_i = b; end
    @(negedge clk) begin
      byte_vld_i = 1'b0;
      r_vld = ack_vld_o; r_ack = ack_o; r_we = otp_we_o;
      r_off = otp_off_o; r_data = otp_data_o;
    end
  endtask

  task automatic open_cmd(input logic [7:0] hi);
    do_start(); send(8'hA2); send(hi); send(8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ack_vld", ack_vld_o, 0); chk("R1 ack", ack_o, 0); chk("R1 we", otp_we_o, 0);
    rst_n = 1'b1;
    // R10: byte before any start
    send(8'hA2); chk("R10 vld", r_vld, 1); chk("R10 ack", r_ack, 0); chk("R10 we", r_we, 0);

    // R2/R3: select sweep
    for (int v = 0; v < 256; v++) begin
      do_start(); send(8'(v));
      chk("R2 sel vld", r_vld, 1);
      chk("R2 sel ack", r_ack, (v == 8'hA2) ? 1 : 0);
      if (v != 8'hA2) begin send(8'h00); chk("R3 dropped", r_ack, 0); end
      do_stop();
    end
    // R4: address high sweep
    for (int v = 0; v < 256; v++) begin
      do_start(); send(8'hA2); send(8'(v));
      chk("R4 adrh ack", r_ack, ((v % 16) == 0) ? 1 : 0);
      if ((v % 16) != 0) begin send(8'h00); chk("R4 dropped", r_ack, 0); end
      do_stop();
    end
    // R5: address low sweep
    for (int v = 0; v < 256; v++) begin
      open_cmd(8'h00);
      // open_cmd sent 00 already; restart to place v in address low
      do_start(); send(8'hA2); send(8'h50); send(8'(v));
      chk("R5 adrl ack", r_ack, (v == 0) ? 1 : 0);
      send(8'h11);
      chk("R5 follow ack", r_ack, (v == 0) ? 1 : 0);
      chk("R5 follow we", r_we, (v == 0) ? 1 : 0);
      do_stop();
    end
    // R6/R7: long data run with wrap, don't-care upper nibble
    open_cmd(8'hF0);
    for (int i = 0; i < 70; i++) begin
      send(8'((i * 7 + 3) % 256));
      chk("R6 ack", r_ack, 1); chk("R6 we", r_we, 1);
      chk("R6 data", r_data, (i * 7 + 3) % 256);
      chk("R7 offset", r_off, i % 64);
    end
    do_stop();
    // R10: after stop
    send(8'h42); chk("R10 after stop ack", r_ack, 0); chk("R10 after stop we", r_we, 0);
    // R8: permit low
    open_cmd(8'h30);
    wr_permit_i = 1'b0; send(8'h55);
    chk("R8 ack", r_ack, 0); chk("R8 we", r_we, 0);
    wr_permit_i = 1'b1; send(8'h56);
    chk("R8 dropped ack", r_ack, 0); chk("R8 dropped we", r_we, 0);
    do_stop();
    // R9: stop mid address
    do_start(); send(8'hA2); do_stop(); send(8'h00);
    chk("R9 stop mid ack", r_ack, 0);
    // R9: repeated start mid data, then new command restarts offset (R7)
    open_cmd(8'h00); send(8'h01); send(8'h02);
    do_start(); send(8'h00); chk("R9 restart sel", r_ack, 0);
    open_cmd(8'h00); send(8'h99);
    chk("R7 restart off", r_off, 0); chk("R7 restart we", r_we, 1);
    // R9: start coincident with byte gives no response
    @(negedge clk) begin start_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'h77; end
    @(negedge clk) begin
      start_i = 1'b0; byte_vld_i = 1'b0;
      chk("R9 collide vld", ack_vld_o, 0); chk("R9 collide we", otp_we_o, 0);
    end
    send(8'hA2); chk("R9 after collide sel", r_ack, 1);
    do_stop();
    // R11: idle cycle has no response
    @(negedge clk) chk("R11 idle vld", ack_vld_o, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule